// File: doc/BRIEF.md
# Dual-Mode Control Word Capture

This block is the front end that captures the control word of a tone encoder/decoder. The word has eight bits: six tone-select bits (D5 down to D0), a transmit/receive select and a phase/test bit. Software or a host controller loads the word in one of two ways. In parallel mode all eight bits come from their own pins. In serial mode the word is shifted in over two of the data pins, which are reused as serial data and serial clock. One load pin governs the holding latches. In parallel mode it works as a transparent-latch enable. In serial mode it works as a transfer strobe.

Serial mode is chosen by a fixed code on the two highest tone-select pins. All pins are asynchronous. They pass through two-flop synchronisers clocked by the system clock, and every edge of the serial clock or the load pin is detected on the synchronised copies. The shift register is kept apart from the output latches, so shifting never disturbs the outputs. The outputs are the latched word and a serial-mode indicator.

Top module: `ctl_word_capture`

## Requirements
- R1: After reset all eight latched bits read 1, which is the idle state of the pulled-up pins, and the serial-mode indicator reads 0.
- R2: The serial-mode indicator is 1 exactly when the D5 pin is 1 and the D4 pin is 0. It follows the pins after the synchroniser delay.
- R3: In parallel mode, while the load pin is high, the outputs follow the pins within three clocks. The word image is {D5..D0, TX/RX, PTL}, with D5 in bit 7 and PTL in bit 0.
- R4: While the load pin is low, the latched outputs do not change, whatever the other pins do.
- R5: In parallel mode, the value present when the load pin falls is the one kept. Pin changes that arrive in the same clock as the fall are not captured.
- R6: In serial mode, the D3 pin is sampled on each rising edge of the D2 pin. The word is sent D5 first and PTL last, eight clocks per word, and a low-high-low strobe on the load pin moves it to the outputs.
- R7: While a serial word is being shifted with the load pin low, the outputs keep their previous value.
- R8: In serial mode the parallel pins have no effect on the outputs, even while the load pin is high.
- R9: Rising edges on the D2 pin while parallel mode is selected do not shift the serial register.
- R10: When more than eight serial clocks arrive before a strobe, the last eight bits received form the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_i | input | 1 | Latch enable (parallel mode) or transfer strobe (serial mode) |
| dpin_i | input | 6 | Data pins D5..D0; D5/D4 select the mode, D3 is serial data, D2 is serial clock |
| txrx_i | input | 1 | Transmit/receive select pin (parallel mode) |
| ptl_i | input | 1 | Phase/test pin (parallel mode) |
| tone_o | output | 6 | Latched tone-select bits D5..D0 |
| txrx_o | output | 1 | Latched transmit/receive select |
| ptl_o | output | 1 | Latched phase/test bit |
| serial_mode_o | output | 1 | 1 while serial mode is selected |

## Verification
The hardest situation to reach from the ports is a serial clock edge that arrives while parallel mode is selected. Such an edge must leave the hidden shift register untouched, and nothing shows this at the outputs until a later strobe. To reach it, the stimulus first loads a known serial word. It then leaves serial mode and toggles the D2 pin several times with changing D3 data. Finally it returns to serial mode and strobes without shifting, so the outputs show whether the register kept the earlier word. The parallel sweep covers every word that does not carry the serial-select code, and the serial sweep covers all 256 words.

// File: rtl/ccl_pkg.sv
// Package for the control word capture block.
// Holds the shared width rule and the latch source-select type.
// Assumes that the word always carries two control bits beyond the tone bits.
package ccl_pkg;

    localparam int CTRL_EXTRA = 2;

    // Latch source: the synchronised parallel pins or the serial shift register
    typedef enum logic {
        SRC_PAR = 1'b0,
        SRC_SER = 1'b1
    } ccl_src_e;

    // Total control word width for a given number of tone bits
    function automatic int ctrl_width(input int tone_w);
        return tone_w + CTRL_EXTRA;
    endfunction

endpackage

// File: rtl/ccl_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Each bit is resynchronised on its own and resets to 1, matching the pulled-up
// idle level of the pins. Assumes that bits which must be seen together change
// together and stay stable for several clocks.
module ccl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stg [STAGES];

    // Shift the pin levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= '1;
            end
        end else begin
            stg[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q_o = stg[STAGES-1];

endmodule

// File: rtl/ccl_shift.sv
// Serial input shift register with rising-edge detection of a serial clock.
// Bits enter at the LSB, so the first bit received ends at the MSB.
// Assumes synchronised inputs; shifting is allowed only while en_i is high.
module ccl_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_i,
    input  logic         sclk_i,
    input  logic         sdat_i,
    output logic [W-1:0] word_o
);

    logic sclk_q;
    logic sclk_rise;

    // Remember the previous serial clock level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b1;
        end else begin
            sclk_q <= sclk_i;
        end
    end

    assign sclk_rise = sclk_i & ~sclk_q;

    // Shift one data bit in on each enabled serial clock rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '1;
        end else if (en_i && sclk_rise) begin
            word_o <= {word_o[W-2:0], sdat_i};
        end
    end

endmodule

// File: rtl/ccl_hold.sv
// Holding latches for the control word, emulated with flops.
// While load_i is high the register follows the selected source every clock.
// While it is low the register holds, so the value at the fall is the one kept.
// Assumes synchronised load and source-select inputs.
module ccl_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         serial_i,
    input  logic [W-1:0] par_word_i,
    input  logic [W-1:0] ser_word_i,
    output logic [W-1:0] word_o
);

    import ccl_pkg::*;

    ccl_src_e     src;
    logic [W-1:0] src_word;

    // Choose the latch source from the current mode
    always_comb begin
        src      = serial_i ? SRC_SER : SRC_PAR;
        src_word = (src == SRC_SER) ? ser_word_i : par_word_i;
    end

    // Transparent while load is high, held while it is low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o <= '1;
        end else if (load_i) begin
            word_o <= src_word;
        end
    end

endmodule

// File: rtl/ctl_word_capture.sv
// Control word capture front end: parallel/serial loading of a tone control word.
// Synchronises all pins, decodes serial mode from the two highest tone pins,
// shifts serial data on D2 rises and latches the word under the load pin.
// Assumes TONE_W >= 4, so that the mode, data and clock pins exist.
module ctl_word_capture #(
    parameter int TONE_W      = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [TONE_W-1:0] dpin_i,
    input  logic              txrx_i,
    input  logic              ptl_i,
    output logic [TONE_W-1:0] tone_o,
    output logic              txrx_o,
    output logic              ptl_o,
    output logic              serial_mode_o
);

    localparam int CTRL_W = ccl_pkg::ctrl_width(TONE_W);
    localparam int SYNC_W = CTRL_W + 1;
    localparam int OFF    = ccl_pkg::CTRL_EXTRA;
    localparam int SEL_HI = TONE_W - 1 + OFF;
    localparam int SEL_LO = TONE_W - 2 + OFF;
    localparam int SDAT   = TONE_W - 3 + OFF;
    localparam int SCLK   = TONE_W - 4 + OFF;

    logic [SYNC_W-1:0] pin_vec;
    logic [SYNC_W-1:0] s_vec;
    logic [CTRL_W-1:0] s_par;
    logic              s_load;
    logic              serial_mode;
    logic [CTRL_W-1:0] shift_word;
    logic [CTRL_W-1:0] held_word;

    // Gather every pin into one vector for synchronisation
    assign pin_vec = {load_i, dpin_i, txrx_i, ptl_i};

    ccl_sync #(
        .W      (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_vec),
        .q_o   (s_vec)
    );

    // Split the synchronised vector and decode the mode code
    always_comb begin
        s_load      = s_vec[CTRL_W];
        s_par       = s_vec[CTRL_W-1:0];
        serial_mode = s_par[SEL_HI] & ~s_par[SEL_LO];
    end

    ccl_shift #(
        .W (CTRL_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (serial_mode),
        .sclk_i (s_par[SCLK]),
        .sdat_i (s_par[SDAT]),
        .word_o (shift_word)
    );

    ccl_hold #(
        .W (CTRL_W)
    ) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (s_load),
        .serial_i   (serial_mode),
        .par_word_i (s_par),
        .ser_word_i (shift_word),
        .word_o     (held_word)
    );

    // Drive the outputs from the held word and the mode decode
    assign tone_o        = held_word[CTRL_W-1:OFF];
    assign txrx_o        = held_word[1];
    assign ptl_o         = held_word[0];
    assign serial_mode_o = serial_mode;

endmodule

// File: rtl/ccl_checker.sv
// Assertion checker for ctl_word_capture, bound to every instance of it.
// Assumes the default two-stage synchroniser when relating outputs to past pins.
module ccl_checker #(
    parameter int TONE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_i,
    input logic [TONE_W-1:0] dpin_i,
    input logic              txrx_i,
    input logic              ptl_i,
    input logic [TONE_W-1:0] tone_o,
    input logic              txrx_o,
    input logic              ptl_o,
    input logic              serial_mode_o
);

    logic [2:0]        cyc;
    logic              hist_ok;
    logic [TONE_W+1:0] word;

    // Count cycles since reset, saturating, to guard the history lookups
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc <= '0;
        end else if (cyc != 3'd7) begin
            cyc <= cyc + 3'd1;
        end
    end

    assign hist_ok = (cyc >= 3'd4);
    assign word    = {tone_o, txrx_o, ptl_o};

    AST_RESET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (word == '1 && !serial_mode_o)); // R1

    AST_MODE_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        hist_ok |-> serial_mode_o ==
            ($past(dpin_i[TONE_W-1], 2) && !$past(dpin_i[TONE_W-2], 2))); // R2

    AST_PAR_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && $past(load_i, 3) &&
         !($past(dpin_i[TONE_W-1], 3) && !$past(dpin_i[TONE_W-2], 3)))
        |-> word == {$past(dpin_i, 3), $past(txrx_i, 3), $past(ptl_i, 3)}); // R3

    AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (hist_ok && !$past(load_i, 2)) |=> $stable(word)); // R4

endmodule

bind ctl_word_capture ccl_checker #(.TONE_W(TONE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_i        (load_i),
    .dpin_i        (dpin_i),
    .txrx_i        (txrx_i),
    .ptl_i         (ptl_i),
    .tone_o        (tone_o),
    .txrx_o        (txrx_o),
    .ptl_o         (ptl_o),
    .serial_mode_o (serial_mode_o)
);

// File: tb/tb_ctl_word_capture.sv
module tb_ctl_word_capture;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b1;
    logic [5:0] dp = '1;
    logic       txrx = 1'b1;
    logic       ptl = 1'b1;
    logic [5:0] tone;
    logic       txrx_q;
    logic       ptl_q;
    logic       smode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctl_word_capture dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load),
        .dpin_i        (dp),
        .txrx_i        (txrx),
        .ptl_i         (ptl),
        .tone_o        (tone),
        .txrx_o        (txrx_q),
        .ptl_o         (ptl_q),
        .serial_mode_o (smode)
    );

    function automatic logic [7:0] outw();
        return {tone, txrx_q, ptl_q};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic set_par(input logic [7:0] w);
        dp   = w[7:2];
        txrx = w[1];
        ptl  = w[0];
    endtask

    // Serial setup: mode code on D5/D4, clock low, junk on the rest
    task automatic enter_serial(input logic [7:0] junk);
        @(negedge clk);
        load = 1'b0;
        dp = {2'b10, 1'b0, 1'b0, junk[1:0]};
        txrx = junk[2];
        ptl = junk[3];
        settle();
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); dp[3] = b; repeat (3) @(negedge clk);
        dp[2] = 1'b1; repeat (3) @(negedge clk);
        dp[2] = 1'b0; repeat (3) @(negedge clk);
    endtask

    task automatic strobe();
        @(negedge clk); load = 1'b1; settle();
        @(negedge clk); load = 1'b0; settle();
    endtask

    initial begin
        logic [7:0] exp_w;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R1 reset word", outw(), 8'hFF);
        chk("R1 reset mode", {7'd0, smode}, 8'h00);

        // Parallel sweep over every word without the serial-select code
        for (int w = 0; w < 256; w++) begin
            logic [7:0] wv;
            wv = w[7:0];
            if (wv[7] && !wv[6]) continue;
            @(negedge clk); set_par(wv); load = 1'b1; settle();
            chk("R3 transparent", outw(), wv);
            @(negedge clk); set_par(~wv); load = 1'b0; settle();
            chk("R5 value at fall kept", outw(), wv);
            @(negedge clk); set_par(wv ^ 8'h5A); settle();
            chk("R4 held while low", outw(), wv);
        end
        exp_w = 8'hFF ^ 8'h00;
        exp_w = outw();

        // Mode decode over all D5/D4 codes
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); load = 1'b0; dp[5:4] = c[1:0]; dp[2] = 1'b0; settle();
            chk("R2 mode decode", {7'd0, smode}, {7'd0, (c == 2)});
            chk("R4 held during mode change", outw(), exp_w);
        end

        // Serial sweep over all 256 words
        for (int w = 0; w < 256; w++) begin
            logic [7:0] wv;
            wv = w[7:0];
            enter_serial(~wv);
            for (int i = 7; i >= 0; i--) send_bit(wv[i]);
            chk("R7 outputs stable while shifting", outw(), exp_w);
            @(negedge clk); load = 1'b1; settle();
            chk("R6 serial word after strobe", outw(), wv);
            @(negedge clk); dp[1:0] = wv[1:0] ^ 2'b11; txrx = ~txrx; ptl = ~ptl; dp[3] = ~dp[3];
            settle();
            chk("R8 parallel pins ignored", outw(), wv);
            @(negedge clk); load = 1'b0; settle();
            exp_w = wv;
        end

        // Known word, then serial clocks in parallel mode must not shift
        enter_serial(8'h00);
        for (int i = 7; i >= 0; i--) send_bit(8'hA5 >> i);
        strobe();
        chk("R6 known word", outw(), 8'hA5);
        @(negedge clk); dp = 6'b000000; settle();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); dp[3] = k[0]; repeat (3) @(negedge clk);
            dp[2] = 1'b1; repeat (3) @(negedge clk);
            dp[2] = 1'b0; repeat (3) @(negedge clk);
        end
        chk("R4 held in parallel toggles", outw(), 8'hA5);
        @(negedge clk); dp = 6'b100000; settle();
        strobe();
        chk("R9 no shift in parallel mode", outw(), 8'hA5);

        // Twelve serial clocks: the last eight bits win
        enter_serial(8'h00);
        for (int i = 11; i >= 0; i--) send_bit((12'hABC >> i) & 1);
        strobe();
        chk("R10 last eight bits", outw(), 8'hBC);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule